// File: doc/BRIEF.md
# DMA Channel Control and Status Register Block

This block is the software-visible register file of a single descriptor-driven DMA channel. It connects to a plain 32-bit read/write bus. It holds four word registers: channel control, channel status, the address of the descriptor being worked on, and the address of the next descriptor to fetch. From the control register it drives a level enable and a one-cycle append pulse into the channel engine. That pulse tells a running engine to re-read the next-descriptor pointer after software has linked in new work.

In the other direction, the engine reports its activity level together with single-cycle events: end of transfer, end of chain and four kinds of bus error. Each event is latched into its own sticky status bit. Software clears a sticky bit by writing 1 to it. The interrupt output is raised whenever any sticky bit is set.

Bus reads are combinational: `bus_rdata` is valid in the same cycle that `bus_sel` is high with `bus_wr` low. Writes take effect at the clock edge on which `bus_sel` and `bus_wr` are both high.

Top module: `dmach_csr`

## Requirements
- R1: After reset, `ch_enable`, `ch_append` and `irq` are 0, and every register reads 0, apart from status bit 13, which always follows `eng_busy`.
- R2: Byte offsets are: control 0x00, status 0x04, current descriptor 0x08, next descriptor 0x24. The next-descriptor register is 32 bits read/write and appears on `ch_next_desc`.
- R3: Control bit 0 is the channel enable. A write stores it, it reads back at bit 0, and it drives `ch_enable` from the cycle after the write. Every other control bit reads 0.
- R4: A control write with bit 1 and bit 0 both set makes `ch_append` high for exactly the one cycle after the write. With bit 0 clear, no pulse is produced. Bit 1 always reads back as 0.
- R5: Status bit 13 mirrors `eng_busy` combinationally, and bus writes do not change it.
- R6: A one-cycle pulse on an event input sets its sticky status bit from the next cycle onward. The mapping is: `eng_eot` to bit 12, `eng_eoc` to bit 11, `eng_err[0]` (internal master abort) to bit 3, `eng_err[1]` (internal target abort) to bit 4, `eng_err[2]` (memory controller abort) to bit 5, and `eng_err[3]` (internal parity) to bit 9.
- R7: Writing 1 to a sticky status bit clears it. Writing 0 leaves it unchanged. Each bit is cleared independently of the others.
- R8: If an event and a clearing write hit the same bit in the same cycle, the bit stays set.
- R9: `irq` is high exactly while at least one sticky status bit is set. `eng_busy` does not contribute to it.
- R10: The current-descriptor register loads `eng_cur_addr` on a cycle with `eng_cur_load` high and reads back the value from the next cycle. Bus writes to offset 0x08 are ignored.
- R11: Reads of any other offset return 0. Writes to any other offset change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| eng_busy | input | 1 | Engine activity level |
| eng_eot | input | 1 | End-of-transfer event pulse |
| eng_eoc | input | 1 | End-of-chain event pulse |
| eng_err | input | 4 | Error event pulses: master abort, target abort, memory controller abort, parity |
| eng_cur_load | input | 1 | Load strobe for the current-descriptor register |
| eng_cur_addr | input | 32 | Current descriptor address from the engine |
| ch_enable | output | 1 | Channel enable level |
| ch_append | output | 1 | One-cycle resume request |
| ch_next_desc | output | 32 | Next-descriptor pointer |
| irq | output | 1 | Interrupt, OR of the sticky flags |

## Verification
The assertions assume that the engine inputs are known (not X) from the first cycle after reset. They also assume that `eng_cur_load` is low while reset is asserted, so the descriptor-stability property has a defined reference value. The bench drives every engine input to 0 before releasing reset. It changes inputs only on falling edges and holds each event high for a single cycle. It overlaps an event with a clearing write only in the dedicated same-cycle test.

// File: rtl/dmach_csr_pkg.sv
`timescale 1ns/1ps
package dmach_csr_pkg;
  localparam int DW = 32;

  // byte offsets
  localparam int OFS_CTRL = 'h00;
  localparam int OFS_STAT = 'h04;
  localparam int OFS_CUR  = 'h08;
  localparam int OFS_NEXT = 'h24;

  // control bits
  localparam int CTL_EN  = 0;
  localparam int CTL_APP = 1;

  // status bits
  localparam int ST_BUSY = 13;

  // sticky flag index: 0..3 errors, 4 end of chain, 5 end of transfer
  localparam int ERR_N  = 4;
  localparam int FLAG_N = ERR_N + 2;

  function automatic int flag_pos(input int idx);
    case (idx)
      0:       return 3;   // internal master abort
      1:       return 4;   // internal target abort
      2:       return 5;   // memory controller abort
      3:       return 9;   // internal parity
      4:       return 11;  // end of chain
      default: return 12;  // end of transfer
    endcase
  endfunction
endpackage

// File: rtl/dmach_csr_decode.sv
`timescale 1ns/1ps
module dmach_csr_decode #(
  parameter int ADDR_W = 8
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              hit_ctrl,
  output logic              hit_stat,
  output logic              hit_cur,
  output logic              hit_next,
  output logic              wr_ctrl,
  output logic              wr_stat,
  output logic              wr_next
);
  import dmach_csr_pkg::*;

  always_comb begin
    hit_ctrl = bus_sel && (bus_addr == ADDR_W'(OFS_CTRL));
    hit_stat = bus_sel && (bus_addr == ADDR_W'(OFS_STAT));
    hit_cur  = bus_sel && (bus_addr == ADDR_W'(OFS_CUR));
    hit_next = bus_sel && (bus_addr == ADDR_W'(OFS_NEXT));
    wr_ctrl  = hit_ctrl && bus_wr;
    wr_stat  = hit_stat && bus_wr;
    wr_next  = hit_next && bus_wr;
  end
endmodule

// File: rtl/dmach_csr_ctrl.sv
`timescale 1ns/1ps
module dmach_csr_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctrl,
  input  logic wd_en,
  input  logic wd_app,
  output logic enable,
  output logic append
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= 1'b0;
      append <= 1'b0;
    end else begin
      if (wr_ctrl) enable <= wd_en;
      append <= wr_ctrl && wd_app && wd_en;
    end
  end

  // R4: a resume pulse only ever accompanies an enabled channel
  a_r4_append_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    append |-> enable);

  // R3: enable moves only after a control write
  a_r3_enable_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_ctrl) |-> $stable(enable));
endmodule

// File: rtl/dmach_csr_flags.sv
`timescale 1ns/1ps
module dmach_csr_flags #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr_wr,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag[i] <= 1'b0;
      else        flag[i] <= (flag[i] && !clr_wr[i]) || set_ev[i];
    end

    // R6 and R8: an event always leaves the flag set, even under a clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[i] |=> flag[i]);

    // R7: a clear without a competing event drops the flag
    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr[i] && !set_ev[i]) |=> !flag[i]);

    // R7: without a clear the flag is sticky
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !clr_wr[i]) |=> flag[i]);
  end
endmodule

// File: rtl/dmach_csr_desc.sv
`timescale 1ns/1ps
module dmach_csr_desc #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_next,
  input  logic [DW-1:0] wdata,
  input  logic          cur_load,
  input  logic [DW-1:0] cur_addr,
  output logic [DW-1:0] cur_q,
  output logic [DW-1:0] next_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      next_q <= '0;
    end else begin
      if (cur_load) cur_q  <= cur_addr;
      if (wr_next)  next_q <= wdata;
    end
  end

  // R10: the current pointer only follows the engine load strobe
  a_r10_cur_only_engine: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cur_load) |-> $stable(cur_q));

  // R2: the next pointer only follows a bus write to its offset
  a_r2_next_only_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_next) |-> $stable(next_q));
endmodule

// File: rtl/dmach_csr.sv
`timescale 1ns/1ps
module dmach_csr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              eng_busy,
  input  logic              eng_eot,
  input  logic              eng_eoc,
  input  logic [3:0]        eng_err,
  input  logic              eng_cur_load,
  input  logic [31:0]       eng_cur_addr,
  output logic              ch_enable,
  output logic              ch_append,
  output logic [31:0]       ch_next_desc,
  output logic              irq
);
  import dmach_csr_pkg::*;

  logic hit_ctrl, hit_stat, hit_cur, hit_next;
  logic wr_ctrl, wr_stat, wr_next;
  logic [FLAG_N-1:0] set_vec, clr_vec, flags;
  logic [DW-1:0] cur_q, stat_word, ctrl_word;

  dmach_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .hit_ctrl(hit_ctrl), .hit_stat(hit_stat), .hit_cur(hit_cur), .hit_next(hit_next),
    .wr_ctrl(wr_ctrl), .wr_stat(wr_stat), .wr_next(wr_next)
  );

  dmach_csr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl),
    .wd_en(bus_wdata[CTL_EN]), .wd_app(bus_wdata[CTL_APP]),
    .enable(ch_enable), .append(ch_append)
  );

  assign set_vec = {eng_eot, eng_eoc, eng_err};

  always_comb begin
    for (int i = 0; i < FLAG_N; i++)
      clr_vec[i] = wr_stat && bus_wdata[flag_pos(i)];
  end

  dmach_csr_flags #(.N(FLAG_N)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_ev(set_vec), .clr_wr(clr_vec), .flag(flags)
  );

  dmach_csr_desc #(.DW(DW)) u_desc (
    .clk(clk), .rst_n(rst_n), .wr_next(wr_next), .wdata(bus_wdata),
    .cur_load(eng_cur_load), .cur_addr(eng_cur_addr),
    .cur_q(cur_q), .next_q(ch_next_desc)
  );

  assign irq = |flags;

  always_comb begin
    stat_word = '0;
    stat_word[ST_BUSY] = eng_busy;
    for (int i = 0; i < FLAG_N; i++)
      stat_word[flag_pos(i)] = flags[i];
    ctrl_word = '0;
    ctrl_word[CTL_EN] = ch_enable;
  end

  always_comb begin
    bus_rdata = '0;
    if (!bus_wr) begin
      if (hit_ctrl) bus_rdata = ctrl_word;
      if (hit_stat) bus_rdata = stat_word;
      if (hit_cur)  bus_rdata = cur_q;
      if (hit_next) bus_rdata = ch_next_desc;
    end
  end

  // R9: an interrupt can only rise after some engine event
  a_r9_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|set_vec));

  // R9: an interrupt can only fall after a status write
  a_r9_irq_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_stat));
endmodule

// File: tb/dmach_csr_tb.sv
`timescale 1ns/1ps
module dmach_csr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eng_busy = 1'b0, eng_eot = 1'b0, eng_eoc = 1'b0;
  logic [3:0]  eng_err = '0;
  logic        eng_cur_load = 1'b0;
  logic [31:0] eng_cur_addr = '0;
  logic        ch_enable, ch_append, irq;
  logic [31:0] ch_next_desc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dmach_csr #(.ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_busy(eng_busy), .eng_eot(eng_eot), .eng_eoc(eng_eoc), .eng_err(eng_err),
    .eng_cur_load(eng_cur_load), .eng_cur_addr(eng_cur_addr),
    .ch_enable(ch_enable), .ch_append(ch_append), .ch_next_desc(ch_next_desc), .irq(irq)
  );

  // vector: {op, addr, data, expect}; op 0 = write, 1 = read and compare
  localparam int NV = 18;
  localparam logic [73:0] VEC [NV] = '{
    {2'd1, 8'h00, 32'h0,        32'h0},
    {2'd0, 8'h24, 32'hDEADBEE0, 32'h0},
    {2'd1, 8'h24, 32'h0,        32'hDEADBEE0},
    {2'd0, 8'h00, 32'h00000001, 32'h0},
    {2'd1, 8'h00, 32'h0,        32'h00000001},
    {2'd0, 8'h00, 32'hFFFFFFFC, 32'h0},
    {2'd1, 8'h00, 32'h0,        32'h0},
    {2'd0, 8'h08, 32'h12345678, 32'h0},
    {2'd1, 8'h08, 32'h0,        32'h0},
    {2'd0, 8'h0C, 32'hFFFFFFFF, 32'h0},
    {2'd1, 8'h0C, 32'h0,        32'h0},
    {2'd1, 8'h24, 32'h0,        32'hDEADBEE0},
    {2'd0, 8'h20, 32'h00000001, 32'h0},
    {2'd1, 8'h00, 32'h0,        32'h0},
    {2'd1, 8'h20, 32'h0,        32'h0},
    {2'd1, 8'h04, 32'h0,        32'h0},
    {2'd0, 8'h24, 32'h00000040, 32'h0},
    {2'd1, 8'h24, 32'h0,        32'h00000040}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 enable", {31'b0, ch_enable}, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd = ch_next_desc;
    chk("R1 next pointer", rd, 32'h0);
    rst_n = 1'b1;
    bus_read(8'h04, rd); chk("R1 status", rd, 32'h0);
    bus_read(8'h08, rd); chk("R1 current", rd, 32'h0);

    // table walk: R2 R3 R10 R11
    for (int k = 0; k < NV; k++) begin
      if (VEC[k][73:72] == 2'd0) bus_write(VEC[k][71:64], VEC[k][63:32]);
      else begin
        bus_read(VEC[k][71:64], rd);
        chk($sformatf("R2 R3 R10 R11 vector %0d", k), rd, VEC[k][31:0]);
      end
    end
    chk("R2 next pointer port", ch_next_desc, 32'h00000040);
    chk("R11 no interrupt from stray writes", {31'b0, irq}, 32'h0);

    // R3: enable port
    bus_write(8'h00, 32'h1);
    chk("R3 enable port", {31'b0, ch_enable}, 32'h1);
    bus_write(8'h00, 32'h0);
    chk("R3 disable port", {31'b0, ch_enable}, 32'h0);

    // R4: append pulse
    bus_write(8'h00, 32'h3);
    chk("R4 pulse after write", {31'b0, ch_append}, 32'h1);
    @(negedge clk);
    chk("R4 pulse one cycle", {31'b0, ch_append}, 32'h0);
    bus_read(8'h00, rd); chk("R4 append reads 0", rd, 32'h1);
    bus_write(8'h00, 32'h2);
    chk("R4 no pulse when disabled", {31'b0, ch_append}, 32'h0);
    chk("R4 enable dropped", {31'b0, ch_enable}, 32'h0);
    @(negedge clk);
    chk("R4 still no pulse", {31'b0, ch_append}, 32'h0);

    // R5: busy mirror
    eng_busy = 1'b1;
    bus_read(8'h04, rd); chk("R5 busy mirror", rd, 32'h00002000);
    bus_write(8'h04, 32'hFFFFFFFF);
    bus_read(8'h04, rd); chk("R5 busy unaffected by write", rd, 32'h00002000);
    chk("R9 busy gives no irq", {31'b0, irq}, 32'h0);
    eng_busy = 1'b0;

    // R6: event latching
    @(negedge clk); eng_eot = 1'b1;
    @(negedge clk); eng_eot = 1'b0;
    chk("R9 irq on flag", {31'b0, irq}, 32'h1);
    bus_read(8'h04, rd); chk("R6 end of transfer bit 12", rd, 32'h00001000);
    @(negedge clk); eng_eoc = 1'b1;
    @(negedge clk); eng_eoc = 1'b0;
    bus_read(8'h04, rd); chk("R6 end of chain bit 11", rd, 32'h00001800);
    @(negedge clk); eng_err = 4'b0001;
    @(negedge clk); eng_err = 4'b0100;
    @(negedge clk); eng_err = 4'b0000;
    bus_read(8'h04, rd); chk("R6 master and memory aborts bits 3 5", rd, 32'h00001828);
    @(negedge clk); eng_err = 4'b1010;
    @(negedge clk); eng_err = 4'b0000;
    bus_read(8'h04, rd); chk("R6 all error bits", rd, 32'h00001A38);

    // R7: write-one-to-clear
    bus_write(8'h04, 32'h00001000);
    bus_read(8'h04, rd); chk("R7 clear one bit", rd, 32'h00000A38);
    bus_write(8'h04, 32'h0);
    bus_read(8'h04, rd); chk("R7 zero write keeps", rd, 32'h00000A38);
    bus_write(8'h04, 32'h00000A38);
    bus_read(8'h04, rd); chk("R7 clear all", rd, 32'h0);
    chk("R9 irq clears", {31'b0, irq}, 32'h0);

    // R8: set wins over clear in the same cycle
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h00000010;
    eng_err = 4'b0010;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; eng_err = '0;
    bus_read(8'h04, rd); chk("R8 set wins", rd, 32'h00000010);
    chk("R8 irq held", {31'b0, irq}, 32'h1);
    bus_write(8'h04, 32'h00000010);
    chk("R9 irq released", {31'b0, irq}, 32'h0);

    // R10: engine loads current descriptor
    @(negedge clk); eng_cur_load = 1'b1; eng_cur_addr = 32'hCAFE0100;
    @(negedge clk); eng_cur_load = 1'b0; eng_cur_addr = 32'h0;
    bus_read(8'h08, rd); chk("R10 current loaded", rd, 32'hCAFE0100);
    bus_write(8'h08, 32'h0);
    bus_read(8'h08, rd); chk("R10 bus write ignored", rd, 32'hCAFE0100);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule